// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a bank of already-synchronized port input levels and raises an active-low interrupt request whenever the pins differ from a stored reference pattern. The reference is the pin pattern captured at the most recent access to the port. Reset loads a reference of all ones, which matches the state the port takes at power-up. The interrupt drops again on its own if the pins go back to the reference pattern. It also drops when the serial bus front end reports an access to this target.

The bus front end supplies two single-cycle clear pulses. One is issued at the acknowledge bit of a read, aligned to the rising clock edge. The other is issued at the acknowledge bit of a write, aligned to the falling clock edge. Because the front end times the pulses, both have the same effect here. A clear empties the request and loads the present pin pattern as the new reference, so the generator is re-armed for the next change. The request is produced both as an active-low level and as an output-enable that pulls low. The enable form lets the pad be wired-OR with other devices on one shared interrupt line.

Top module: `port_change_irq`

## Requirements
- R1: After reset the reference holds all ones, `int_n` is 1 and `int_oe` is 0. With every pin at 1 and no clear pulse, `int_n` stays 1.
- R2: If the pin pattern differs from the reference in any bit (a rise or a fall) during a cycle with no clear pulse, `int_n` is 0 from the next rising clock edge.
- R3: If the pins equal the reference during a cycle with no clear pulse, `int_n` is 1 after the next rising clock edge, even when no access took place.
- R4: A `rd_ack_clr` pulse makes `int_n` 1 after that edge. The same edge loads the pin pattern of that cycle into the reference.
- R5: A `wr_ack_clr` pulse has the same effect as R4. Asserting both pulses in one cycle also has that effect.
- R6: A pin change presented in the same cycle as a clear pulse is absorbed into the new reference. It raises no interrupt while the pins keep that pattern.
- R7: After a clear, any later difference between the pins and the new reference raises the interrupt again, as in R2.
- R8: `int_oe` is 1 exactly when `int_n` is 0, so the pad is only ever driven low or released.
- R9: Without a clear pulse the reference never changes. An interrupt then stays asserted for as long as the pins differ from the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| port_in | input | WIDTH | Synchronized port pin levels |
| rd_ack_clr | input | 1 | One-cycle clear pulse from a read access acknowledge |
| wr_ack_clr | input | 1 | One-cycle clear pulse from a write access acknowledge |
| int_n | output | 1 | Active-low interrupt request level |
| int_oe | output | 1 | Pull-low enable for an open-drain interrupt pad |

## Verification
The hardest case to reach is a pin change that lands in exactly the same cycle as a clear pulse. In that case the reference swallows the change and no request follows. The bench drives the new pin pattern together with a read pulse, a write pulse, and both pulses at once. It then holds the pattern for several cycles to show that nothing fires. After that it steps back to the old pattern to show the generator was re-armed. A long stretch of pseudo-random pin patterns with sparse clear pulses then mixes returns to the reference, clears and fresh changes. Every cycle of that stretch is compared against a behavioural reference model.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

  localparam int unsigned PCHG_DEF_WIDTH = 8;

  // Source of a re-arm event; both sources act identically on the reference.
  typedef enum logic [1:0] {
    REARM_NONE  = 2'b00,
    REARM_READ  = 2'b01,
    REARM_WRITE = 2'b10,
    REARM_BOTH  = 2'b11
  } rearm_src_e;

  function automatic logic rearm_active(input rearm_src_e src);
    return (src != REARM_NONE);
  endfunction

endpackage

// File: rtl/pchg_rst_sync.sv
module pchg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/pchg_ref_store.sv
module pchg_ref_store
  import pchg_pkg::*;
#(
  parameter int unsigned WIDTH = PCHG_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rearm_src_e       rearm_src,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] ref_q
);

  localparam logic [WIDTH-1:0] REF_RESET = {WIDTH{1'b1}};

  logic             ref_en;
  logic [WIDTH-1:0] ref_d;

  always_comb begin
    ref_en = rearm_active(rearm_src);
    ref_d  = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= REF_RESET;
    end else if (ref_en) begin
      ref_q <= ref_d;
    end
  end

  // R6: a re-arm captures the pins seen in that very cycle
  a_r6_capture_on_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_src != REARM_NONE) |=> (ref_q == $past(pins)));

  // R9: no re-arm, no movement of the reference
  a_r9_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_src == REARM_NONE) |=> $stable(ref_q));

endmodule

// File: rtl/pchg_cmp.sv
module pchg_cmp #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] pins,
  input  logic [WIDTH-1:0] ref_val,
  output logic             any_diff
);

  logic [WIDTH-1:0] bit_diff;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
    assign bit_diff[gi] = pins[gi] ^ ref_val[gi];
  end

  assign any_diff = |bit_diff;

endmodule

// File: rtl/pchg_irq_out.sv
module pchg_irq_out
  import pchg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rearm_src_e rearm_src,
  input  logic       any_diff,
  output logic       int_n,
  output logic       int_oe
);

  logic irq_q;
  logic irq_d;

  always_comb begin
    if (rearm_active(rearm_src)) begin
      irq_d = 1'b0;
    end else begin
      irq_d = any_diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign int_oe = irq_q;
  assign int_n  = ~irq_q;

  // R2: a seen difference without re-arm asserts the request next cycle
  a_r2_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (any_diff && (rearm_src == REARM_NONE)) |=> !int_n);

  // R3: agreement without re-arm releases the request next cycle
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_diff && (rearm_src == REARM_NONE)) |=> int_n);

endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
  import pchg_pkg::*;
#(
  parameter int unsigned WIDTH = PCHG_DEF_WIDTH,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] port_in,
  input  logic             rd_ack_clr,
  input  logic             wr_ack_clr,
  output logic             int_n,
  output logic             int_oe
);

  logic             rst_int_n;
  rearm_src_e       rearm_src;
  logic [WIDTH-1:0] ref_val;
  logic             any_diff;

  always_comb begin
    rearm_src = rearm_src_e'({wr_ack_clr, rd_ack_clr});
  end

  pchg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pchg_ref_store #(.WIDTH(WIDTH)) u_ref (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rearm_src (rearm_src),
    .pins      (port_in),
    .ref_q     (ref_val)
  );

  pchg_cmp #(.WIDTH(WIDTH)) u_cmp (
    .pins     (port_in),
    .ref_val  (ref_val),
    .any_diff (any_diff)
  );

  pchg_irq_out u_irq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rearm_src (rearm_src),
    .any_diff  (any_diff),
    .int_n     (int_n),
    .int_oe    (int_oe)
  );

  // R4: read acknowledge clears the request
  a_r4_read_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_ack_clr |=> int_n);

  // R5: write acknowledge clears the request
  a_r5_write_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_ack_clr |=> int_n);

  // R8: the pad is driven only while the request is active
  a_r8_drive_matches: assert property (@(posedge clk) disable iff (!rst_int_n)
    int_oe != int_n);

  // R7: after a clear, a pin pattern that differs from the one captured is flagged
  a_r7_rearmed: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((rd_ack_clr || wr_ack_clr) ##1 (!rd_ack_clr && !wr_ack_clr && (port_in != $past(port_in))))
    |=> !int_n);

endmodule

// File: tb/sim_port_change_irq.sv
`timescale 1ns/1ps
module sim_port_change_irq;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] port_in;
  logic         rd_ack_clr;
  logic         wr_ack_clr;
  logic         int_n;
  logic         int_oe;

  int vectors;
  int miscompares;
  logic [W-1:0] m_ref;
  logic         m_irq;

  port_change_irq #(.WIDTH(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_in    (port_in),
    .rd_ack_clr (rd_ack_clr),
    .wr_ack_clr (wr_ack_clr),
    .int_n      (int_n),
    .int_oe     (int_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic compare(input string tag);
    vectors++;
    if (int_n !== ~m_irq) begin
      miscompares++;
      $display("FAIL %s: int_n actual %b expected %b", tag, int_n, ~m_irq);
    end
    vectors++;
    if (int_oe !== m_irq) begin
      miscompares++;
      $display("FAIL R8: int_oe actual %b expected %b (%s)", int_oe, m_irq, tag);
    end
  endtask

  // Called at a falling edge: drive, model the rising edge, compare at next falling edge.
  task automatic step(input logic [W-1:0] p, input logic rd, input logic wr, input string tag);
    port_in    = p;
    rd_ack_clr = rd;
    wr_ack_clr = wr;
    @(posedge clk);
    if (rd || wr) begin
      m_irq = 1'b0;
      m_ref = p;
    end else begin
      m_irq = (p != m_ref);
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1_500_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    vectors     = 0;
    miscompares = 0;
    m_ref       = '1;
    m_irq       = 1'b0;
    port_in     = '1;
    rd_ack_clr  = 1'b0;
    wr_ack_clr  = 1'b0;
    rst_n       = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(8'hFF, 1'b0, 1'b0, "R1 idle all ones");

    // single-bit fall, then hold
    step(8'hFE, 1'b0, 1'b0, "R2 bit0 fall");
    for (int i = 0; i < 5; i++) step(8'hFE, 1'b0, 1'b0, "R9 held without clear");
    step(8'hFF, 1'b0, 1'b0, "R3 return to reference");
    step(8'h7F, 1'b0, 1'b0, "R2 bit7 fall");

    // read clear re-arms with 7F
    step(8'h7F, 1'b1, 1'b0, "R4 read clear");
    step(8'h7F, 1'b0, 1'b0, "R4 reference now 7F");
    step(8'hFF, 1'b0, 1'b0, "R7 rise after clear detected");
    step(8'hFF, 1'b0, 1'b1, "R5 write clear");
    step(8'hFF, 1'b0, 1'b0, "R5 reference now FF");
    step(8'hEF, 1'b0, 1'b0, "R7 fall after write clear");
    step(8'hEF, 1'b1, 1'b1, "R5 both clears");

    // change coincident with clear is swallowed
    step(8'h00, 1'b0, 1'b1, "R6 change with write clear");
    for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 1'b0, "R6 swallowed");
    step(8'h5A, 1'b1, 1'b0, "R6 change with read clear");
    for (int i = 0; i < 3; i++) step(8'h5A, 1'b0, 1'b0, "R6 swallowed");
    step(8'h00, 1'b0, 1'b0, "R7 old pattern now differs");
    step(8'h5A, 1'b0, 1'b0, "R3 back to new reference");
    step(8'hA5, 1'b1, 1'b1, "R6 change with both clears");
    step(8'hA5, 1'b0, 1'b0, "R6 swallowed");

    // mixed pseudo-random stretch
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] p;
      int r;
      r = $urandom_range(0, 15);
      if (r < 6) p = m_ref;
      else if (r < 10) p = m_ref ^ (8'h01 << $urandom_range(0, 7));
      else p = W'($urandom);
      step(p, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0), "R2 mixed pattern");
    end

    // reset again mid-interrupt
    step(8'h0F, 1'b0, 1'b0, "R2 before second reset");
    rst_n = 1'b0;
    m_ref = '1;
    m_irq = 1'b0;
    port_in = '1;
    @(negedge clk);
    compare("R1 second reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(8'hFF, 1'b0, 1'b0, "R1 reference all ones again");
    step(8'hFD, 1'b0, 1'b0, "R2 after second reset");

    finish_run();
  end

endmodule